// File: doc/BRIEF.md
# Shift-Count Command Decoder for a JTAG TAP

This block sits on the device side of a two-pin JTAG link. It observes only the test clock and the mode-select pin and keeps its own copy of the standard 16-state TAP controller. Register-write commands reach it with no data bits. Each value is the number of clock cycles the TAP stays in Shift-DR between one Capture-DR and the Update-DR that follows. All values gathered since the previous visit to Run-Test/Idle make up one command.

Three command forms are recognised. A three-value command `[0, 0, 1]` locks the control level at 2. At control level 2, a two-value command chooses a target register with its first value and writes its second value into that register. A first value of 2 selects the scan-topology register and a first value of 0 selects the mode register. When the mode register holds the state-control code that asks for the classic four-wire protocol, the `four_wire` output goes high. The block never answers a command. Any TAP reset clears the lock and every decoded register, so the host has to send the whole sequence again.

Top module: `tap_shiftcmd_decoder`

## Requirements
- R1: `tap_state` follows the standard TAP transitions with the encodings TLR=15, RTI=12, Select-DR=7, Capture-DR=6, Shift-DR=2, Exit1-DR=1, Pause-DR=3, Exit2-DR=0, Update-DR=5, Select-IR=4. The IR-side states are Capture-IR=14, Shift-IR=10, Exit1-IR=9, Pause-IR=11, Exit2-IR=8 and Update-IR=13. `rst_n` low at a rising `tck` edge forces TLR and clears `ctl_level`, `topo_reg`, `mode_reg` and `four_wire` to 0.
- R2: Five consecutive `tck` edges with `tms` high reach TLR from any state. Four are not enough when starting in Shift-DR. Being in TLR clears the control level and both registers, so a write sent afterwards without a new lock is discarded.
- R3: The value of a segment is the number of rising edges spent in Shift-DR between Capture-DR and Update-DR. A segment that goes Capture, Exit1, optional Pause and Exit2, then Update, has the value 0.
- R4: A command is made of the segments closed since the last entry into RTI. Going from Update-DR through Select-DR (`tms`=1) continues the same command. Segments separated by RTI belong to different commands.
- R5: The command `[0, 0, 1]` sets `ctl_level` to 2.
- R6: At `ctl_level`=2, a two-value command `[2, v]` loads `topo_reg` with v, and `[0, v]` loads `mode_reg` with v. A two-value command with any other first value, or any two-value command sent while the level is not 2, changes nothing.
- R7: `four_wire` is 1 exactly when `mode_reg` equals 1.
- R8: A segment of 31 shift cycles is valid. A longer segment saturates its count and the whole command is discarded.
- R9: A command whose number of segments or whose values match no defined form leaves every output unchanged. This includes forms with one or four segments.
- R10: A register update becomes visible on the second rising edge after the edge that enters RTI, and not on the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state advances on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tms | input | 1 | Test mode select, sampled on rising `tck` |
| tap_state | output | 4 | Current TAP state code |
| ctl_level | output | 2 | Control level (0 or 2) |
| topo_reg | output | CNT_W | Scan-topology register |
| mode_reg | output | CNT_W | Mode register |
| four_wire | output | 1 | High when the mode register selects four-wire operation |

## Verification
The embedded properties check, on every cycle, the following rules. Five high `tms` edges always land in TLR. A finished command is only reported while the TAP is in RTI. A pass through TLR leaves the control level and both registers cleared. The topology register changes only while the level is locked. `four_wire` rises only just after a command. Only the bench scenarios can show what the decoded values actually are. Those scenarios cover the sweep of every first and second value, zero-bit segments through Pause-DR, the 31/32 saturation boundary, malformed segment counts, commands split by RTI, the four-versus-five-edge reset boundary, and the two-edge update latency.

// File: rtl/tapcmd_pkg.sv
// Shared types for the shift-count command decoder.
// Holds the TAP state encoding (standard 4-bit codes), the next-state
// function and the command code constants the decoder matches.
package tapcmd_pkg;

    typedef enum logic [3:0] {
        TS_EX2_DR  = 4'h0,
        TS_EX1_DR  = 4'h1,
        TS_SH_DR   = 4'h2,
        TS_PA_DR   = 4'h3,
        TS_SEL_IR  = 4'h4,
        TS_UPD_DR  = 4'h5,
        TS_CAP_DR  = 4'h6,
        TS_SEL_DR  = 4'h7,
        TS_EX2_IR  = 4'h8,
        TS_EX1_IR  = 4'h9,
        TS_SH_IR   = 4'hA,
        TS_PA_IR   = 4'hB,
        TS_IDLE    = 4'hC,
        TS_UPD_IR  = 4'hD,
        TS_CAP_IR  = 4'hE,
        TS_TLR     = 4'hF
    } tap_state_e;

    localparam int LOCK_LEVEL     = 2;  // level granted by the lock command
    localparam int SEL_TOPO       = 2;  // first value selecting the topology register
    localparam int SEL_MODE       = 0;  // first value selecting the mode register
    localparam int MODE_FOUR_WIRE = 1;  // mode value asking for four-wire operation

    // Standard TAP transition for one rising edge of the test clock.
    function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
        case (s)
            TS_TLR:    return tms ? TS_TLR    : TS_IDLE;
            TS_IDLE:   return tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: return tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: return tms ? TS_EX1_DR : TS_SH_DR;
            TS_SH_DR:  return tms ? TS_EX1_DR : TS_SH_DR;
            TS_EX1_DR: return tms ? TS_UPD_DR : TS_PA_DR;
            TS_PA_DR:  return tms ? TS_EX2_DR : TS_PA_DR;
            TS_EX2_DR: return tms ? TS_UPD_DR : TS_SH_DR;
            TS_UPD_DR: return tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: return tms ? TS_TLR    : TS_CAP_IR;
            TS_CAP_IR: return tms ? TS_EX1_IR : TS_SH_IR;
            TS_SH_IR:  return tms ? TS_EX1_IR : TS_SH_IR;
            TS_EX1_IR: return tms ? TS_UPD_IR : TS_PA_IR;
            TS_PA_IR:  return tms ? TS_EX2_IR : TS_PA_IR;
            TS_EX2_IR: return tms ? TS_UPD_IR : TS_SH_IR;
            TS_UPD_IR: return tms ? TS_SEL_DR : TS_IDLE;
            default:   return TS_TLR;
        endcase
    endfunction

endpackage

// File: rtl/tapcmd_tap_fsm.sv
// TAP controller copy.
// Tracks the 16-state machine from tms on each rising tck edge.
// Assumes tms is stable around the rising edge; rst_n is synchronous.
module tapcmd_tap_fsm
    import tapcmd_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state,
    output tap_state_e state_nxt
);

    // Next state from the standard transition table.
    always_comb state_nxt = tap_next(state, tms);

    // State register; reset parks the controller in Test-Logic-Reset.
    always_ff @(posedge tck) begin
        if (!rst_n) state <= TS_TLR;
        else        state <= state_nxt;
    end

    // Checker: run length of consecutive high tms edges, saturating at 7.
    logic [2:0] ones_q;
    always_ff @(posedge tck) begin
        if (!rst_n)              ones_q <= 3'd0;
        else if (!tms)           ones_q <= 3'd0;
        else if (ones_q != 3'd7) ones_q <= ones_q + 3'd1;
    end

    // R2: five high tms edges always reach Test-Logic-Reset.
    p_five_high_tlr_r2: assert property (@(posedge tck) disable iff (!rst_n)
        (ones_q >= 3'd5) |-> (state == TS_TLR));

endmodule

// File: rtl/tapcmd_seg_collect.sv
// Segment collector.
// Counts Shift-DR cycles between Capture-DR and Update-DR, stores up to
// MAX_SEG segment values and reports the collected command for one cycle
// after the TAP enters Run-Test/Idle. Too many segments or a saturated
// count mark the command bad. Test-Logic-Reset drops everything collected.
module tapcmd_seg_collect
    import tapcmd_pkg::*;
#(
    parameter int CNT_W   = 5,
    parameter int MAX_SEG = 3,
    localparam int NSEG_W = $clog2(MAX_SEG + 2)
) (
    input  logic                             tck,
    input  logic                             rst_n,
    input  tap_state_e                       state,
    input  tap_state_e                       state_nxt,
    output logic                             cmd_valid,
    output logic [NSEG_W-1:0]                cmd_nseg,
    output logic [MAX_SEG-1:0][CNT_W-1:0]    cmd_vals,
    output logic                             cmd_bad
);

    localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [NSEG_W-1:0] NSEG_CAP = NSEG_W'(MAX_SEG + 1);

    logic [CNT_W-1:0]              cnt_q;
    logic [NSEG_W-1:0]             nseg_q, nseg_c;
    logic [MAX_SEG-1:0][CNT_W-1:0] vals_q, vals_c;
    logic                          bad_q, bad_c;
    logic                          end_cmd;

    // A command closes on every transition into Run-Test/Idle.
    always_comb end_cmd = (state != TS_IDLE) && (state_nxt == TS_IDLE);

    // Shift counter: cleared at Capture-DR, advances per Shift-DR edge, saturates.
    always_ff @(posedge tck) begin
        if (!rst_n || state == TS_CAP_DR)          cnt_q <= '0;
        else if (state == TS_SH_DR && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    // Next collection contents including a segment closing this cycle.
    always_comb begin
        vals_c = vals_q;
        nseg_c = nseg_q;
        bad_c  = bad_q;
        if (state == TS_SH_DR && cnt_q == CNT_MAX) bad_c = 1'b1;
        if (state == TS_UPD_DR) begin
            for (int i = 0; i < MAX_SEG; i++) begin
                if (nseg_q == NSEG_W'(i)) vals_c[i] = cnt_q;
            end
            if (nseg_q >= NSEG_W'(MAX_SEG)) bad_c = 1'b1;
            if (nseg_q != NSEG_CAP) nseg_c = nseg_q + 1'b1;
        end
    end

    // Collection and report registers.
    always_ff @(posedge tck) begin
        if (!rst_n || state == TS_TLR) begin
            nseg_q    <= '0;
            vals_q    <= '0;
            bad_q     <= 1'b0;
            cmd_valid <= 1'b0;
            cmd_nseg  <= '0;
            cmd_vals  <= '0;
            cmd_bad   <= 1'b0;
        end else begin
            cmd_valid <= end_cmd;
            if (end_cmd) begin
                cmd_nseg <= nseg_c;
                cmd_vals <= vals_c;
                cmd_bad  <= bad_c;
                nseg_q   <= '0;
                vals_q   <= '0;
                bad_q    <= 1'b0;
            end else begin
                nseg_q <= nseg_c;
                vals_q <= vals_c;
                bad_q  <= bad_c;
            end
        end
    end

    // R4: a finished command is only reported while the TAP sits in Run-Test/Idle.
    p_cmd_in_idle_r4: assert property (@(posedge tck) disable iff (!rst_n)
        cmd_valid |-> (state == TS_IDLE));

endmodule

// File: rtl/tapcmd_cmd_decode.sv
// Command decoder and register file.
// Matches reported commands against the lock form and the two-value
// register-write form and holds the control level and both registers.
// Assumes MAX_SEG >= 3. Test-Logic-Reset clears all state.
module tapcmd_cmd_decode
    import tapcmd_pkg::*;
#(
    parameter int CNT_W   = 5,
    parameter int MAX_SEG = 3,
    localparam int NSEG_W = $clog2(MAX_SEG + 2)
) (
    input  logic                          tck,
    input  logic                          rst_n,
    input  tap_state_e                    state,
    input  logic                          cmd_valid,
    input  logic [NSEG_W-1:0]             cmd_nseg,
    input  logic [MAX_SEG-1:0][CNT_W-1:0] cmd_vals,
    input  logic                          cmd_bad,
    output logic [1:0]                    ctl_level,
    output logic [CNT_W-1:0]              topo_reg,
    output logic [CNT_W-1:0]              mode_reg,
    output logic                          four_wire
);

    logic is_lock, is_pair;

    // Classify the reported command.
    always_comb begin
        is_lock = cmd_valid && !cmd_bad && cmd_nseg == NSEG_W'(3)
                  && cmd_vals[0] == '0 && cmd_vals[1] == '0
                  && cmd_vals[2] == CNT_W'(1);
        is_pair = cmd_valid && !cmd_bad && cmd_nseg == NSEG_W'(2)
                  && ctl_level == 2'(LOCK_LEVEL);
    end

    // Level and register updates; reset or Test-Logic-Reset clear them.
    always_ff @(posedge tck) begin
        if (!rst_n || state == TS_TLR) begin
            ctl_level <= 2'd0;
            topo_reg  <= '0;
            mode_reg  <= '0;
        end else begin
            if (is_lock) ctl_level <= 2'(LOCK_LEVEL);
            if (is_pair && cmd_vals[0] == CNT_W'(SEL_TOPO)) topo_reg <= cmd_vals[1];
            if (is_pair && cmd_vals[0] == CNT_W'(SEL_MODE)) mode_reg <= cmd_vals[1];
        end
    end

    // Four-wire select follows the mode register code.
    always_comb four_wire = (mode_reg == CNT_W'(MODE_FOUR_WIRE));

    // R2: a cycle in Test-Logic-Reset leaves everything cleared.
    p_tlr_clears_r2: assert property (@(posedge tck) disable iff (!rst_n)
        (state == TS_TLR) |=> (ctl_level == 2'd0 && topo_reg == '0 && mode_reg == '0));

    // R6: the topology register only changes while the level is locked.
    p_write_needs_level_r6: assert property (@(posedge tck) disable iff (!rst_n)
        ((topo_reg != $past(topo_reg)) && ($past(state) != TS_TLR))
        |-> ($past(ctl_level) == 2'(LOCK_LEVEL)));

    // R7: four-wire select only rises right after a reported command.
    p_four_wire_after_cmd_r7: assert property (@(posedge tck) disable iff (!rst_n)
        $rose(four_wire) |-> $past(cmd_valid));

endmodule

// File: rtl/tap_shiftcmd_decoder.sv
// Top level of the shift-count command decoder.
// Joins the TAP copy, the segment collector and the command decoder.
// Driven only by tck and tms; produces no response on any pin.
module tap_shiftcmd_decoder
    import tapcmd_pkg::*;
#(
    parameter int CNT_W   = 5,
    parameter int MAX_SEG = 3
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             tms,
    output logic [3:0]       tap_state,
    output logic [1:0]       ctl_level,
    output logic [CNT_W-1:0] topo_reg,
    output logic [CNT_W-1:0] mode_reg,
    output logic             four_wire
);

    localparam int NSEG_W = $clog2(MAX_SEG + 2);

    tap_state_e                    state, state_nxt;
    logic                          cmd_valid, cmd_bad;
    logic [NSEG_W-1:0]             cmd_nseg;
    logic [MAX_SEG-1:0][CNT_W-1:0] cmd_vals;

    tapcmd_tap_fsm u_fsm (
        .tck       (tck),
        .rst_n     (rst_n),
        .tms       (tms),
        .state     (state),
        .state_nxt (state_nxt)
    );

    tapcmd_seg_collect #(.CNT_W(CNT_W), .MAX_SEG(MAX_SEG)) u_collect (
        .tck       (tck),
        .rst_n     (rst_n),
        .state     (state),
        .state_nxt (state_nxt),
        .cmd_valid (cmd_valid),
        .cmd_nseg  (cmd_nseg),
        .cmd_vals  (cmd_vals),
        .cmd_bad   (cmd_bad)
    );

    tapcmd_cmd_decode #(.CNT_W(CNT_W), .MAX_SEG(MAX_SEG)) u_decode (
        .tck       (tck),
        .rst_n     (rst_n),
        .state     (state),
        .cmd_valid (cmd_valid),
        .cmd_nseg  (cmd_nseg),
        .cmd_vals  (cmd_vals),
        .cmd_bad   (cmd_bad),
        .ctl_level (ctl_level),
        .topo_reg  (topo_reg),
        .mode_reg  (mode_reg),
        .four_wire (four_wire)
    );

    // Expose the TAP state code.
    always_comb tap_state = state;

endmodule

// File: tb/tap_shiftcmd_decoder_bench.sv
// Bench: sweeps every first/second value pair and the boundary cases,
// with a bench-side model of the level and register contents.
module tap_shiftcmd_decoder_bench;

    logic       tck = 1'b0;
    logic       rst_n = 1'b0;
    logic       tms = 1'b1;
    logic [3:0] tap_state;
    logic [1:0] ctl_level;
    logic [4:0] topo_reg, mode_reg;
    logic       four_wire;

    int checks = 0;
    int fails  = 0;
    int e_lvl = 0, e_topo = 0, e_mode = 0;

    always #4 tck = ~tck;

    tap_shiftcmd_decoder u_tap_shiftcmd_decoder (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tap_state(tap_state),
        .ctl_level(ctl_level), .topo_reg(topo_reg), .mode_reg(mode_reg),
        .four_wire(four_wire)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive tms just after a rising edge, then wait for the next edge.
    task automatic step(input logic t);
        tms = t;
        @(posedge tck);
        #1;
    endtask

    // One capture segment with n shift cycles, starting at RTI or Update-DR.
    task automatic seg(input int n, input bit pause);
        step(1'b1);
        step(1'b0);
        if (n == 0) begin
            step(1'b1);
            if (pause) begin
                step(1'b0);
                step(1'b0);
                step(1'b1);
            end
            step(1'b1);
        end else begin
            step(1'b0);
            for (int i = 0; i < n - 1; i++) step(1'b0);
            step(1'b1);
            step(1'b1);
        end
    endtask

    // Full command: segments, entry into RTI, one more edge for the update.
    task automatic cmd(input int nseg, input int v0, input int v1 = 0,
                       input int v2 = 0, input int v3 = 0);
        int vv[4];
        vv = '{v0, v1, v2, v3};
        for (int i = 0; i < nseg; i++) seg(vv[i], 1'b0);
        step(1'b0);
        step(1'b0);
    endtask

    task automatic check_all(input string req);
        chk({req, " level"}, ctl_level, e_lvl);
        chk({req, " topo"}, topo_reg, e_topo);
        chk({req, " mode"}, mode_reg, e_mode);
        chk({req, " four_wire"}, four_wire, (e_mode == 1) ? 1 : 0);
    endtask

    task automatic go_idle();
        for (int i = 0; i < 5; i++) step(1'b1);
        step(1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge tck);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge tck);
        #1;
        chk("R1 reset state", tap_state, 15);
        check_all("R1 reset");
        rst_n = 1'b1;
        step(1'b0);
        chk("R1 idle code", tap_state, 12);

        // R9: four-segment form before any lock is discarded.
        cmd(4, 0, 0, 1, 0);
        check_all("R9 four segs");
        // R6: write below level 2 is discarded.
        cmd(2, 2, 9);
        check_all("R6 unlocked write");

        // R5/R3/R10: lock with a zero-bit segment through Pause-DR.
        seg(0, 1'b1);
        seg(0, 1'b0);
        seg(1, 1'b0);
        step(1'b0);
        chk("R10 not on first edge", ctl_level, 0);
        step(1'b0);
        e_lvl = 2;
        check_all("R5 lock");

        // R6/R7/R4: sweep every first value 0..4 and second value 0..31.
        for (int a = 0; a < 5; a++) begin
            for (int b = 0; b < 32; b++) begin
                cmd(2, a, b);
                if (a == 2) e_topo = b;
                if (a == 0) e_mode = b;
                check_all("R6 sweep");
            end
        end

        // R8: 31 accepted, 32 saturates and is discarded.
        cmd(2, 2, 31);
        e_topo = 31;
        check_all("R8 count 31");
        cmd(2, 2, 32);
        check_all("R8 count 32");
        cmd(2, 0, 40);
        check_all("R8 count 40");
        cmd(2, 0, 1);
        e_mode = 1;
        check_all("R7 four wire set");

        // R9: one-segment and wrong three-segment forms are discarded.
        cmd(1, 2);
        check_all("R9 one seg");
        cmd(3, 2, 5, 0);
        check_all("R9 three seg");
        // R4: values separated by RTI are two separate commands.
        cmd(1, 2);
        cmd(1, 7);
        check_all("R4 split by idle");

        // R2: four high edges from Shift-DR stop at Select-IR, the fifth resets.
        step(1'b1);
        step(1'b0);
        step(1'b0);
        for (int i = 0; i < 4; i++) step(1'b1);
        chk("R2 four highs state", tap_state, 4);
        check_all("R2 four highs kept");
        step(1'b1);
        chk("R2 five highs state", tap_state, 15);
        step(1'b1);
        e_lvl = 0; e_topo = 0; e_mode = 0;
        check_all("R2 cleared");
        step(1'b0);
        cmd(2, 2, 9);
        check_all("R2 relock needed");

        // R1: rst_n clears decoded state.
        cmd(3, 0, 0, 1);
        cmd(2, 0, 1);
        e_lvl = 2; e_mode = 1;
        check_all("R1 before rst");
        rst_n = 1'b0;
        @(posedge tck);
        #1;
        e_lvl = 0; e_mode = 0;
        chk("R1 rst state", tap_state, 15);
        check_all("R1 rst clears");
        rst_n = 1'b1;
        go_idle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule